// File: doc/BRIEF.md
# Banked Mode Register File with Exception Entry

This block holds a processor's sixteen visible general registers, its current program status word (CPSR) and the live saved status word (SPSR), together with the hidden copies that each privileged mode owns. A mode-switch request loads a new CPSR. When the new mode uses a different bank, the stack pointer (R13), the link register (R14) and the SPSR of the old mode are moved into storage, and those of the new mode are brought in. The fast-interrupt mode also has private copies of R8 to R12.

An exception request names one of six causes. In a single clock the block moves to the mode that serves the cause and saves the old CPSR into the new mode's SPSR. It also sets the interrupt and abort masks, leaves the compact instruction state, writes the return address into R14 and loads R15 with the vector address. A single write port and a combinational read port give the surrounding pipeline access to the visible registers.

Top module: `mode_bank_core`

## Requirements
- R1: After a synchronous active-low reset the CPSR reads 0x000001D3, which is mode field [4:0] = 0x13 (supervisor) with the A (bit 8), I (bit 7) and F (bit 6) mask bits set. The SPSR reads 0 and all sixteen visible registers read 0.
- R2: With `wr_en` high and no higher-priority request, `wr_data` is written into visible register `wr_idx` of the current mode at the clock edge. `rd_data` shows visible register `rd_idx` combinationally.
- R3: A switch to a legal mode that uses the current bank loads `sw_cpsr` into the CPSR and leaves every visible register and the SPSR unchanged. This covers a switch to the current mode itself and a switch between user (0x10) and system (0x1F), which share one bank.
- R4: A switch to a legal mode with a different bank loads `sw_cpsr` into the CPSR. It stores the live R13, R14 and SPSR into the old bank and loads them from the new bank. There are six banks: user/system, supervisor 0x13, abort 0x17, undefined 0x1B, IRQ 0x12 and FIQ 0x11.
- R5: Entering FIQ mode (0x11) from another bank also stores live R8 to R12 as the common copies and loads the FIQ copies. Leaving FIQ mode does the reverse. R0 to R7 and R15 are never affected.
- R6: An exception request with `exc_kind` 0 (undefined), 1 (software interrupt), 2 (prefetch abort), 3 (data abort), 4 (IRQ) or 5 (FIQ) takes effect at the next clock edge. The new mode is undefined, supervisor, abort, abort, IRQ or FIQ respectively, with the bank exchange of R4 and R5.
- R7: On exception entry the CPSR keeps its bits [31:6], except that bit 5 (T) is cleared and the mode field is replaced. I is set for every cause, A is also set for aborts, IRQ and FIQ, and F is also set for FIQ.
- R8: On exception entry the new mode's SPSR receives the CPSR from before the entry. The new mode's R14 receives the old R15 plus 0, 0, 4, 8, 4 or 4 for causes 0 to 5.
- R9: On exception entry R15 becomes the vector base plus 0x04, 0x08, 0x0C, 0x10, 0x18 or 0x1C for causes 0 to 5. The base is 0xFFFF0000 while `hi_vectors` is high and 0 otherwise.
- R10: A switch whose mode field is not one of the seven legal encodings, and an exception request with `exc_kind` 6 or 7, change no state. Either one sets `mode_err` high for exactly the one cycle after the request.
- R11: An exception request has priority over a switch request, which has priority over a write. The lower-priority request in the same cycle is ignored, even when the higher one is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write visible register |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 4 | Register index for the read |
| rd_data | output | 32 | Visible register contents |
| sw_req | input | 1 | Mode-switch request |
| sw_cpsr | input | 32 | New CPSR value for the switch |
| exc_req | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception cause |
| hi_vectors | input | 1 | Select the high vector base |
| cpsr_o | output | 32 | Current CPSR |
| spsr_o | output | 32 | Live SPSR of the current mode |
| mode_err | output | 1 | Illegal request flag, one cycle |

## Verification
Before the main sweep, every register of each of the seven modes is loaded with a value that encodes its mode and index. This lets any value that arrives from the wrong bank, or stays behind in the wrong one, be told apart. The bench then tries every ordered pair of modes. Same-bank pairs show that nothing moves, pairs between banks show the R13/R14/SPSR exchange, and pairs involving FIQ show the five-register exchange. Each of the six causes is entered from all seven modes under both vector bases, starting with the T bit set and all masks clear. A return to the starting mode then proves that the old bank was saved. All 32 mode encodings, the two unused causes and combined requests then exercise error handling and priority.

// File: rtl/mode_bank_pkg.sv
// Package mode_bank_pkg
// Shared mode encodings, CPSR bit positions, bank numbering and exception
// cause codes for the banked register file. Assumes a 5-bit mode field in
// CPSR bits [4:0].
package mode_bank_pkg;

    localparam logic [4:0] M_USR = 5'h10;
    localparam logic [4:0] M_FIQ = 5'h11;
    localparam logic [4:0] M_IRQ = 5'h12;
    localparam logic [4:0] M_SVC = 5'h13;
    localparam logic [4:0] M_ABT = 5'h17;
    localparam logic [4:0] M_UND = 5'h1B;
    localparam logic [4:0] M_SYS = 5'h1F;

    localparam int NBANK    = 6;
    localparam int BANK_W   = 3;
    localparam int NHI      = 5;
    localparam int HI_FIRST = 8;
    localparam int SP_IDX   = 13;
    localparam int LR_IDX   = 14;
    localparam int PC_IDX   = 15;

    localparam int BIT_T = 5;
    localparam int BIT_F = 6;
    localparam int BIT_I = 7;
    localparam int BIT_A = 8;

    typedef logic [BANK_W-1:0] bank_idx_t;

    typedef enum logic [2:0] {
        EK_UND  = 3'd0,
        EK_SWI  = 3'd1,
        EK_PABT = 3'd2,
        EK_DABT = 3'd3,
        EK_IRQ  = 3'd4,
        EK_FIQ  = 3'd5
    } exc_kind_e;

    // True for the seven mode encodings the block accepts.
    function automatic logic mode_legal(input logic [4:0] m);
        case (m)
            M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: mode_legal = 1'b1;
            default:                                         mode_legal = 1'b0;
        endcase
    endfunction

    // Storage bank serving a mode; user and system share bank 0.
    function automatic bank_idx_t bank_of(input logic [4:0] m);
        case (m)
            M_SVC:   bank_of = 3'd1;
            M_ABT:   bank_of = 3'd2;
            M_UND:   bank_of = 3'd3;
            M_IRQ:   bank_of = 3'd4;
            M_FIQ:   bank_of = 3'd5;
            default: bank_of = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_vector_map.sv
// Module exc_vector_map
// Purely combinational decode of an exception cause into its target mode,
// CPSR mask bits, return-address adjustment and vector address.
// Assumes the cause is one of six codes; codes 6 and 7 report not legal.
module exc_vector_map
    import mode_bank_pkg::*;
#(
    parameter int             DW      = 32,
    parameter logic [DW-1:0]  HI_BASE = 32'hFFFF_0000
) (
    input  logic [2:0]    kind,
    input  logic          hi_sel,
    output logic          legal,
    output logic [4:0]    tgt_mode,
    output logic [DW-1:0] mask_bits,
    output logic [DW-1:0] lr_adj,
    output logic [DW-1:0] vec_addr
);

    logic [7:0] vec_off;
    logic [3:0] lr_off;

    // Per-cause table of mode, masks, link adjustment and vector slot.
    always_comb begin
        legal     = 1'b1;
        tgt_mode  = M_UND;
        mask_bits = '0;
        mask_bits[BIT_I] = 1'b1;
        lr_off    = 4'd0;
        vec_off   = 8'h00;
        case (kind)
            EK_UND: begin
                tgt_mode = M_UND;
                vec_off  = 8'h04;
            end
            EK_SWI: begin
                tgt_mode = M_SVC;
                vec_off  = 8'h08;
            end
            EK_PABT: begin
                tgt_mode = M_ABT;
                mask_bits[BIT_A] = 1'b1;
                lr_off   = 4'd4;
                vec_off  = 8'h0C;
            end
            EK_DABT: begin
                tgt_mode = M_ABT;
                mask_bits[BIT_A] = 1'b1;
                lr_off   = 4'd8;
                vec_off  = 8'h10;
            end
            EK_IRQ: begin
                tgt_mode = M_IRQ;
                mask_bits[BIT_A] = 1'b1;
                lr_off   = 4'd4;
                vec_off  = 8'h18;
            end
            EK_FIQ: begin
                tgt_mode = M_FIQ;
                mask_bits[BIT_A] = 1'b1;
                mask_bits[BIT_F] = 1'b1;
                lr_off   = 4'd4;
                vec_off  = 8'h1C;
            end
            default: begin
                legal     = 1'b0;
                mask_bits = '0;
            end
        endcase
    end

    // Widen the small offsets and place the vector on the selected base.
    always_comb begin
        lr_adj   = DW'(lr_off);
        vec_addr = (hi_sel ? HI_BASE : '0) + DW'(vec_off);
    end

endmodule

// File: rtl/bank_store.sv
// Module bank_store
// Hidden storage for the per-bank stack pointer, link register and saved
// status word, plus the two five-entry copies of R8..R12 (common and FIQ).
// Assumes old_bank differs from new_bank whenever swap_en is high.
module bank_store
    import mode_bank_pkg::*;
#(
    parameter int DW       = 32,
    parameter int N_BANKS  = NBANK,
    parameter int N_HI     = NHI
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     swap_en,
    input  bank_idx_t                old_bank,
    input  bank_idx_t                new_bank,
    input  logic [DW-1:0]            sp_in,
    input  logic [DW-1:0]            lr_in,
    input  logic [DW-1:0]            psr_in,
    output logic [DW-1:0]            sp_out,
    output logic [DW-1:0]            lr_out,
    output logic [DW-1:0]            psr_out,
    input  logic                     fiq_leave,
    input  logic                     fiq_enter,
    input  logic [N_HI-1:0][DW-1:0]  hi_in,
    output logic [N_HI-1:0][DW-1:0]  hi_out
);

    logic [DW-1:0] sp_mem  [N_BANKS];
    logic [DW-1:0] lr_mem  [N_BANKS];
    logic [DW-1:0] psr_mem [N_BANKS];

    logic [N_HI-1:0][DW-1:0] common_hi_q;
    logic [N_HI-1:0][DW-1:0] fiq_hi_q;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [DW-1:0] sp_r, lr_r, psr_r;

        // Capture the outgoing mode's three registers into this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_r  <= '0;
                lr_r  <= '0;
                psr_r <= '0;
            end else if (swap_en && (old_bank == bank_idx_t'(b))) begin
                sp_r  <= sp_in;
                lr_r  <= lr_in;
                psr_r <= psr_in;
            end
        end

        assign sp_mem[b]  = sp_r;
        assign lr_mem[b]  = lr_r;
        assign psr_mem[b] = psr_r;
    end

    // Select the incoming mode's three registers.
    always_comb begin
        sp_out  = '0;
        lr_out  = '0;
        psr_out = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (new_bank == bank_idx_t'(b)) begin
                sp_out  = sp_mem[b];
                lr_out  = lr_mem[b];
                psr_out = psr_mem[b];
            end
        end
    end

    // Park the live R8..R12 in the copy that belongs to the mode being left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            common_hi_q <= '0;
            fiq_hi_q    <= '0;
        end else begin
            if (fiq_leave) fiq_hi_q    <= hi_in;
            if (fiq_enter) common_hi_q <= hi_in;
        end
    end

    // Offer the copy that belongs to the mode being entered.
    assign hi_out = fiq_enter ? fiq_hi_q : common_hi_q;

endmodule

// File: rtl/mode_switch_ctrl.sv
// Module mode_switch_ctrl
// Combinational arbiter and planner: picks exception, switch or write in
// that priority, flags illegal requests, and works out the bank exchange
// and the next CPSR. Assumes the current CPSR mode field is always legal.
module mode_switch_ctrl
    import mode_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cpsr_q,
    input  logic          exc_req,
    input  logic          exc_legal,
    input  logic [4:0]    exc_mode,
    input  logic [DW-1:0] exc_mask,
    input  logic          sw_req,
    input  logic [DW-1:0] sw_cpsr,
    input  logic          wr_en,
    output logic          do_exc,
    output logic          do_sw,
    output logic          do_wr,
    output logic          bad_req,
    output logic          swap_en,
    output bank_idx_t     old_bank,
    output bank_idx_t     new_bank,
    output logic          fiq_leave,
    output logic          fiq_enter,
    output logic [DW-1:0] cpsr_next
);

    localparam logic [DW-1:0] MODE_T_CLR = ~DW'(6'h3F);

    logic [4:0] cur_mode;
    logic [4:0] tgt_mode;

    assign cur_mode = cpsr_q[4:0];

    // Grant one request and form the CPSR it produces.
    always_comb begin
        do_exc    = 1'b0;
        do_sw     = 1'b0;
        do_wr     = 1'b0;
        bad_req   = 1'b0;
        tgt_mode  = cur_mode;
        cpsr_next = cpsr_q;
        if (exc_req) begin
            if (exc_legal) begin
                do_exc    = 1'b1;
                tgt_mode  = exc_mode;
                cpsr_next = (cpsr_q & MODE_T_CLR) | DW'(exc_mode) | exc_mask;
            end else begin
                bad_req = 1'b1;
            end
        end else if (sw_req) begin
            if (mode_legal(sw_cpsr[4:0])) begin
                do_sw     = 1'b1;
                tgt_mode  = sw_cpsr[4:0];
                cpsr_next = sw_cpsr;
            end else begin
                bad_req = 1'b1;
            end
        end else begin
            do_wr = wr_en;
        end
    end

    // Decide whether banks move and whether the FIQ copies are involved.
    always_comb begin
        old_bank  = bank_of(cur_mode);
        new_bank  = bank_of(tgt_mode);
        swap_en   = (do_exc || do_sw) && (old_bank != new_bank);
        fiq_leave = swap_en && (cur_mode == M_FIQ);
        fiq_enter = swap_en && (tgt_mode == M_FIQ);
    end

endmodule

// File: rtl/mode_bank_core.sv
// Module mode_bank_core
// Top of the banked register file: sixteen live registers, CPSR and live
// SPSR, with hidden bank storage and single-cycle exception entry.
// Assumes at most one request is acted on per cycle (exception, switch,
// write in falling priority) and that reset is synchronous, active low.
module mode_bank_core
    import mode_bank_pkg::*;
#(
    parameter int            DW      = 32,
    parameter logic [DW-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [3:0]    rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          sw_req,
    input  logic [DW-1:0] sw_cpsr,
    input  logic          exc_req,
    input  logic [2:0]    exc_kind,
    input  logic          hi_vectors,
    output logic [DW-1:0] cpsr_o,
    output logic [DW-1:0] spsr_o,
    output logic          mode_err
);

    localparam int NREG = 16;
    localparam logic [DW-1:0] RST_PSR = DW'(M_SVC) | (DW'(1) << BIT_A)
                                      | (DW'(1) << BIT_I) | (DW'(1) << BIT_F);

    logic [DW-1:0] gpr_q [NREG];
    logic [DW-1:0] gpr_d [NREG];
    logic [DW-1:0] cpsr_q, cpsr_d;
    logic [DW-1:0] spsr_q, spsr_d;
    logic          err_q;

    logic          ev_legal;
    logic [4:0]    ev_mode;
    logic [DW-1:0] ev_mask, ev_lr_adj, ev_vec;

    logic          do_exc, do_sw, do_wr, bad_req;
    logic          swap_en, fiq_leave, fiq_enter;
    bank_idx_t     old_bank, new_bank;
    logic [DW-1:0] cpsr_next;

    logic [DW-1:0] bk_sp, bk_lr, bk_psr;
    logic [NHI-1:0][DW-1:0] hi_live, hi_bank;

    exc_vector_map #(.DW(DW), .HI_BASE(HI_BASE)) u_vmap (
        .kind      (exc_kind),
        .hi_sel    (hi_vectors),
        .legal     (ev_legal),
        .tgt_mode  (ev_mode),
        .mask_bits (ev_mask),
        .lr_adj    (ev_lr_adj),
        .vec_addr  (ev_vec)
    );

    mode_switch_ctrl #(.DW(DW)) u_ctrl (
        .cpsr_q    (cpsr_q),
        .exc_req   (exc_req),
        .exc_legal (ev_legal),
        .exc_mode  (ev_mode),
        .exc_mask  (ev_mask),
        .sw_req    (sw_req),
        .sw_cpsr   (sw_cpsr),
        .wr_en     (wr_en),
        .do_exc    (do_exc),
        .do_sw     (do_sw),
        .do_wr     (do_wr),
        .bad_req   (bad_req),
        .swap_en   (swap_en),
        .old_bank  (old_bank),
        .new_bank  (new_bank),
        .fiq_leave (fiq_leave),
        .fiq_enter (fiq_enter),
        .cpsr_next (cpsr_next)
    );

    for (genvar h = 0; h < NHI; h++) begin : g_hi
        assign hi_live[h] = gpr_q[HI_FIRST + h];
    end

    bank_store #(.DW(DW), .N_BANKS(NBANK), .N_HI(NHI)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_en   (swap_en),
        .old_bank  (old_bank),
        .new_bank  (new_bank),
        .sp_in     (gpr_q[SP_IDX]),
        .lr_in     (gpr_q[LR_IDX]),
        .psr_in    (spsr_q),
        .sp_out    (bk_sp),
        .lr_out    (bk_lr),
        .psr_out   (bk_psr),
        .fiq_leave (fiq_leave),
        .fiq_enter (fiq_enter),
        .hi_in     (hi_live),
        .hi_out    (hi_bank)
    );

    // Form next live registers: write, bank exchange, then exception entry.
    always_comb begin
        for (int r = 0; r < NREG; r++) gpr_d[r] = gpr_q[r];
        spsr_d = spsr_q;
        cpsr_d = (do_exc || do_sw) ? cpsr_next : cpsr_q;
        if (do_wr) gpr_d[wr_idx] = wr_data;
        if (swap_en) begin
            gpr_d[SP_IDX] = bk_sp;
            gpr_d[LR_IDX] = bk_lr;
            spsr_d        = bk_psr;
        end
        if (fiq_leave || fiq_enter) begin
            for (int h = 0; h < NHI; h++) gpr_d[HI_FIRST + h] = hi_bank[h];
        end
        if (do_exc) begin
            spsr_d        = cpsr_q;
            gpr_d[LR_IDX] = gpr_q[PC_IDX] + ev_lr_adj;
            gpr_d[PC_IDX] = ev_vec;
        end
    end

    // Register the live state and the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) gpr_q[r] <= '0;
            cpsr_q <= RST_PSR;
            spsr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            for (int r = 0; r < NREG; r++) gpr_q[r] <= gpr_d[r];
            cpsr_q <= cpsr_d;
            spsr_q <= spsr_d;
            err_q  <= bad_req;
        end
    end

    assign rd_data  = gpr_q[rd_idx];
    assign cpsr_o   = cpsr_q;
    assign spsr_o   = spsr_q;
    assign mode_err = err_q;

endmodule

// File: rtl/mode_bank_core_chk.sv
// Module mode_bank_core_chk
// Property checker for mode_bank_core, observing only its ports; attached
// to every instance by the bind statement at the end of this file.
module mode_bank_core_chk
    import mode_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_req,
    input logic [4:0]    sw_mode,
    input logic          exc_req,
    input logic [2:0]    exc_kind,
    input logic [DW-1:0] cpsr_o,
    input logic [DW-1:0] spsr_o,
    input logic          mode_err
);

    // Expected destination mode for each cause.
    function automatic logic [4:0] dest_mode(input logic [2:0] k);
        case (k)
            3'd0:    dest_mode = M_UND;
            3'd1:    dest_mode = M_SVC;
            3'd2:    dest_mode = M_ABT;
            3'd3:    dest_mode = M_ABT;
            3'd4:    dest_mode = M_IRQ;
            default: dest_mode = M_FIQ;
        endcase
    endfunction

    // R1: leaving reset shows supervisor mode with all three masks set.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpsr_o[8:0] == 9'h1D3) && (spsr_o == '0));

    // R6: a legal cause lands in its mode on the next cycle.
    a_r6_exc_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_kind < 3'd6) |=> (cpsr_o[4:0] == dest_mode($past(exc_kind))));

    // R7: FIQ entry leaves A, I and F all set and T clear.
    a_r7_fiq_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_kind == 3'd5) |=> (cpsr_o[8:5] == 4'b1110));

    // R8: the new SPSR holds the CPSR from before entry.
    a_r8_spsr_saved: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_kind < 3'd6) |=> (spsr_o == $past(cpsr_o)));

    // R10: an illegal switch flags an error and freezes the status words.
    a_r10_bad_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !exc_req && !mode_legal(sw_mode))
        |=> (mode_err && $stable(cpsr_o) && $stable(spsr_o)));

    // R10: an unused cause flags an error and freezes the CPSR.
    a_r10_bad_kind_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_kind > 3'd5) |=> (mode_err && $stable(cpsr_o)));

    // R3: a switch within the current bank keeps the SPSR.
    a_r3_same_bank_spsr: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !exc_req && mode_legal(sw_mode)
         && bank_of(sw_mode) == bank_of(cpsr_o[4:0])) |=> $stable(spsr_o));

    // R4: the mode field always holds a legal encoding.
    a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(cpsr_o[4:0]));

endmodule

bind mode_bank_core mode_bank_core_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_req   (sw_req),
    .sw_mode  (sw_cpsr[4:0]),
    .exc_req  (exc_req),
    .exc_kind (exc_kind),
    .cpsr_o   (cpsr_o),
    .spsr_o   (spsr_o),
    .mode_err (mode_err)
);

// File: tb/mode_bank_core_tb_top.sv
`timescale 1ns/1ps
// Bench for mode_bank_core: a slot-per-physical-register model predicts
// every visible register, CPSR, SPSR and error flag after each request.
module mode_bank_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        sw_req = 1'b0;
    logic [31:0] sw_cpsr = '0;
    logic        exc_req = 1'b0;
    logic [2:0]  exc_kind = '0;
    logic        hi_vectors = 1'b0;
    logic [31:0] cpsr_o, spsr_o;
    logic        mode_err;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    mode_bank_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .sw_req(sw_req), .sw_cpsr(sw_cpsr), .exc_req(exc_req),
        .exc_kind(exc_kind), .hi_vectors(hi_vectors), .cpsr_o(cpsr_o),
        .spsr_o(spsr_o), .mode_err(mode_err)
    );

    always #10 clk = ~clk;

    // Model: slots 0..15 common registers, 16..22 FIQ R8..R14,
    // 23..30 R13/R14 of supervisor, abort, undefined, IRQ.
    logic [31:0] phys [31];
    logic [31:0] m_spsr [6];
    logic [31:0] m_cpsr;
    logic        m_err;
    logic [4:0]  modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

    function automatic int bnk(input logic [4:0] m);
        case (m)
            5'h13: return 1;
            5'h17: return 2;
            5'h1B: return 3;
            5'h12: return 4;
            5'h11: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_legal(input logic [4:0] m);
        return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13
            || m == 5'h17 || m == 5'h1B || m == 5'h1F;
    endfunction

    function automatic int slot(input logic [4:0] m, input int i);
        if (i < 8 || i == 15) return i;
        if (m == 5'h11) return 16 + (i - 8);
        if (i < 13 || bnk(m) == 0) return i;
        return 23 + (bnk(m) - 1) * 2 + (i - 13);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply the model's view of one exception entry.
    task automatic model_exc(input int k, input logic hv);
        logic [4:0]  nm;
        logic [31:0] old, mask, off, vec;
        case (k)
            0: nm = 5'h1B;
            1: nm = 5'h13;
            2, 3: nm = 5'h17;
            4: nm = 5'h12;
            default: nm = 5'h11;
        endcase
        old  = m_cpsr;
        mask = 32'h80 | ((k >= 2) ? 32'h100 : 32'h0) | ((k == 5) ? 32'h40 : 32'h0);
        off  = (k == 3) ? 32'd8 : ((k >= 2) ? 32'd4 : 32'd0);
        vec  = (hv ? 32'hFFFF_0000 : 32'h0) + ((k < 4) ? (k + 1) * 4 : (k + 2) * 4);
        phys[slot(nm, 14)] = phys[15] + off;
        phys[15]           = vec;
        m_spsr[bnk(nm)]    = old;
        m_cpsr             = (old & ~32'h3F) | {27'd0, nm} | mask;
    endtask

    // Drive one request cycle, then update the model.
    task automatic do_op(input logic e, input logic [2:0] ek, input logic s,
                         input logic [31:0] sc, input logic w, input logic [3:0] wi,
                         input logic [31:0] wd, input logic hv);
        @(negedge clk);
        exc_req = e; exc_kind = ek; sw_req = s; sw_cpsr = sc;
        wr_en = w; wr_idx = wi; wr_data = wd; hi_vectors = hv;
        @(negedge clk);
        exc_req = 1'b0; sw_req = 1'b0; wr_en = 1'b0;
        m_err = 1'b0;
        if (e) begin
            if (ek < 3'd6) model_exc(int'(ek), hv);
            else m_err = 1'b1;
        end else if (s) begin
            if (is_legal(sc[4:0])) m_cpsr = sc;
            else m_err = 1'b1;
        end else if (w) begin
            phys[slot(m_cpsr[4:0], int'(wi))] = wd;
        end
    endtask

    // Compare all outputs with the model; registers read over idle cycles.
    task automatic compare(input string t_psr, input string t_spsr, input string t_reg);
        chk(t_psr, "cpsr", cpsr_o, m_cpsr);
        chk(t_spsr, "spsr", spsr_o, m_spsr[bnk(m_cpsr[4:0])]);
        chk(t_psr, "mode_err", {31'd0, mode_err}, {31'd0, m_err});
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            chk(t_reg, $sformatf("r%0d", i), rd_data, phys[slot(m_cpsr[4:0], i)]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fails++;
                n_checks++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 31; i++) phys[i] = '0;
        for (int i = 0; i < 6; i++) m_spsr[i] = '0;
        m_cpsr = 32'h1D3;
        m_err  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", "R1", "R1");

        // Fill every mode's view with values naming mode and index (R2).
        foreach (modes[mi]) begin
            do_op(0, 0, 1, {27'd0, modes[mi]} | 32'h1C0, 0, 0, 0, 0);
            compare("R4", "R4", "R4");
            for (int i = 0; i < 15; i++) begin
                do_op(0, 0, 0, 0, 1, 4'(i), 32'hA000_0000 | ({27'd0, modes[mi]} << 16) | i, 0);
            end
            compare("R2", "R2", "R2");
        end

        // Every ordered mode pair: same bank (R3), other bank (R4), FIQ (R5).
        foreach (modes[a]) begin
            foreach (modes[b]) begin
                do_op(0, 0, 1, {27'd0, modes[a]} | 32'h2000_00C0, 0, 0, 0, 0);
                compare("R4", "R4", "R5");
                do_op(0, 0, 1, {27'd0, modes[b]} | 32'h4000_0100, 0, 0, 0, 0);
                if (bnk(modes[a]) == bnk(modes[b])) compare("R3", "R3", "R3");
                else if (modes[a] == 5'h11 || modes[b] == 5'h11) compare("R4", "R4", "R5");
                else compare("R4", "R4", "R4");
            end
        end

        // Each cause from each mode under both bases (R6..R9).
        for (int hv = 0; hv < 2; hv++) begin
            foreach (modes[s]) begin
                for (int k = 0; k < 6; k++) begin
                    do_op(0, 0, 1, {27'd0, modes[s]} | 32'hF000_0020, 0, 0, 0, 0);
                    do_op(0, 0, 0, 0, 1, 4'd15, 32'h0000_1000 + k * 32'h40 + hv * 32'h8, 0);
                    do_op(0, 0, 0, 0, 1, 4'd14, 32'h5500_0000 + k, 0);
                    do_op(1, 3'(k), 0, 0, 0, 0, 0, hv[0]);
                    chk("R6", "mode", {27'd0, cpsr_o[4:0]}, {27'd0, m_cpsr[4:0]});
                    compare("R7", "R8", "R9");
                    do_op(0, 0, 1, {27'd0, modes[s]} | 32'h1C0, 0, 0, 0, 0);
                    compare("R4", "R4", "R5");
                end
            end
        end

        // All mode encodings and the unused causes (R10).
        do_op(0, 0, 1, 32'h0000_00D3, 0, 0, 0, 0);
        for (int mv = 0; mv < 32; mv++) begin
            do_op(0, 0, 1, 32'h0000_00C0 | mv, 0, 0, 0, 0);
            compare("R10", "R10", "R10");
        end
        do_op(1, 3'd6, 0, 0, 0, 0, 0, 0);
        compare("R10", "R10", "R10");
        do_op(1, 3'd7, 0, 0, 0, 0, 0, 1);
        compare("R10", "R10", "R10");

        // Priority among simultaneous requests (R11).
        do_op(0, 0, 1, 32'h0000_0010, 0, 0, 0, 0);
        do_op(1, 3'd4, 1, 32'h0000_001F, 1, 4'd0, 32'hDEAD_0001, 0);
        compare("R11", "R11", "R11");
        do_op(1, 3'd7, 1, 32'h0000_0013, 1, 4'd1, 32'hDEAD_0002, 0);
        compare("R11", "R11", "R11");
        do_op(0, 0, 1, 32'h0000_0011, 1, 4'd9, 32'hDEAD_0003, 0);
        compare("R11", "R11", "R11");
        do_op(0, 0, 1, 32'h0000_0003, 1, 4'd2, 32'hDEAD_0004, 0);
        compare("R11", "R11", "R11");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule